// File: doc/BRIEF.md
# Expansion Bus Gating Controller

This block sits on a CPU board between the processor and an external expansion bus. It decides from the request strobes and the low address byte when the three bus buffers may drive: the address buffer, the bidirectional data buffer and the buffer that carries the read, write, memory-cycle and I/O-cycle strobes. It also sets which way the data buffer points.

The address and data buffers open in the same instant a cycle that targets the outside world begins. The strobe buffer opens only at the next falling clock edge, half a period later (125 ns at a 4 MHz clock). This gives address and data time to settle before a strobe shows up on the bus. The strobe buffer closes at once when the cycle ends, so a strobe never outlasts its address. A small window of I/O ports (01h and 02h by default) holds a register on the CPU board itself. Accesses to that window keep every buffer closed, so the board-side reader and the bus never drive the data lines at the same time. The clock line of the bus connector is held low instead of carrying the system clock.

Top module: `exp_bus_gate`

## Requirements
- R1: A memory request (`mreq_n` low) drives `ad_en` high in the same cycle, combinationally, whatever the address. With no request active (`mreq_n` and `iorq_n` both high), `ad_en` is low.
- R2: An I/O request (`iorq_n` low) to port 01h or 02h keeps `ad_en`, `ctl_en` and `dir_in` low.
- R3: An I/O request to any port outside 01h..02h drives `ad_en` high.
- R4: `ctl_en` stays low from the rise of `ad_en` until the next falling edge of `clk`. From that edge it is high for as long as `ad_en` stays high.
- R5: `ctl_en` falls in the same instant as `ad_en`, without waiting for a clock edge, and it is never high while `ad_en` is low.
- R6: `dir_in` is 1 (data flows from the bus to the CPU) only while `ad_en` is high and `rd_n` is low. Otherwise it is 0 (data flows outward).
- R7: `bus_clk` is held at logic 0 at all times.
- R8: While `rst_n` is low, `ctl_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock. The control-buffer delay is timed by its falling edge. |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_lo | input | 8 | Low byte of the CPU address (the I/O port number) |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low (passes through the control buffer only) |
| ad_en | output | 1 | Enable for the address and data buffers, active high |
| ctl_en | output | 1 | Enable for the strobe buffer, active high |
| dir_in | output | 1 | Data buffer direction: 1 is inbound, 0 is outbound |
| bus_clk | output | 1 | Clock line of the bus connector, tied low |

## Verification
The bench targets the boundary ports around the internal window: 00h and 03h must open the bus, and 01h and 02h must not. A decoder that is off by one would open the bus on the board's own register, or lock out a neighbouring peripheral. It steps through cycles that begin, end and switch from an external port to an internal one while the request is held. A strobe enable that is clocked on the wrong edge, or that delays its falling edge, shows up as `ctl_en` high before the falling edge, or as `ctl_en` still high after the address has gone. Read and write cycles to both kinds of target check that a direction term that ignores the gating would turn the data buffer inward on a closed or outbound cycle.

// File: rtl/bgc_pkg.sv
package bgc_pkg;

    // State of the strobe-buffer delay stage
    typedef struct packed {
        logic armed;
    } ctl_state_t;

    localparam ctl_state_t CTL_STATE_RST = '{armed: 1'b0};

endpackage

// File: rtl/bgc_decode.sv
module bgc_decode #(
    parameter int ADDR_W    = 8,
    parameter int INT_BASE  = 1,
    parameter int INT_COUNT = 2
) (
    input  logic [ADDR_W-1:0] addr_lo,
    input  logic              mreq_n,
    input  logic              iorq_n,
    output logic              bus_en
);
    localparam int HIT_W = (INT_COUNT < 1) ? 1 : INT_COUNT;

    logic [HIT_W-1:0] port_hit;
    logic             internal_io;

    // One comparator per port in the internal window
    generate
        if (INT_COUNT < 1) begin : g_no_window
            assign port_hit = '0;
        end else begin : g_window
            for (genvar i = 0; i < INT_COUNT; i++) begin : g_port
                assign port_hit[i] = (addr_lo == ADDR_W'(INT_BASE + i));
            end
        end
    endgenerate

    always_comb begin
        internal_io = !iorq_n && (|port_hit);
        bus_en      = (!mreq_n || !iorq_n) && !internal_io;
    end

endmodule

// File: rtl/bgc_ctl_delay.sv
module bgc_ctl_delay
    import bgc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_en,
    output logic ctl_en
);
    ctl_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.armed = bus_en;
    end

    // Falling-edge stage: opens the strobe buffer half a period late
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CTL_STATE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // Closing is not delayed: gate with the live enable
    assign ctl_en = st_q.armed && bus_en;

endmodule

// File: rtl/bgc_dir.sv
module bgc_dir (
    input  logic bus_en,
    input  logic rd_n,
    output logic dir_in
);
    always_comb begin
        dir_in = bus_en && !rd_n;
    end
endmodule

// File: rtl/exp_bus_gate.sv
module exp_bus_gate #(
    parameter int ADDR_W    = 8,
    parameter int INT_BASE  = 1,
    parameter int INT_COUNT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_lo,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic              ad_en,
    output logic              ctl_en,
    output logic              dir_in,
    output logic              bus_clk
);
    logic bus_en;
    logic wr_unused;

    bgc_decode #(
        .ADDR_W   (ADDR_W),
        .INT_BASE (INT_BASE),
        .INT_COUNT(INT_COUNT)
    ) u_decode (
        .addr_lo(addr_lo),
        .mreq_n (mreq_n),
        .iorq_n (iorq_n),
        .bus_en (bus_en)
    );

    bgc_ctl_delay u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .bus_en(bus_en),
        .ctl_en(ctl_en)
    );

    bgc_dir u_dir (
        .bus_en(bus_en),
        .rd_n  (rd_n),
        .dir_in(dir_in)
    );

    // The write strobe reaches the bus through the control buffer only
    assign wr_unused = wr_n;
    assign ad_en     = bus_en;
    assign bus_clk   = 1'b0;

endmodule

// File: rtl/bgc_checker.sv
module bgc_checker #(
    parameter int ADDR_W    = 8,
    parameter int INT_BASE  = 1,
    parameter int INT_COUNT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_lo,
    input logic              mreq_n,
    input logic              iorq_n,
    input logic              rd_n,
    input logic              ad_en,
    input logic              ctl_en,
    input logic              dir_in,
    input logic              bus_clk
);
    logic in_window;
    assign in_window = (int'(addr_lo) >= INT_BASE) && (int'(addr_lo) < INT_BASE + INT_COUNT);

    AST_INTERNAL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (!iorq_n && in_window) |-> (!ad_en && !ctl_en && !dir_in)); // R2

    AST_MEM_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        !mreq_n |-> ad_en); // R1

    AST_CTL_LATE: assert property (@(negedge clk) disable iff (!rst_n)
        (ad_en && !$past(ad_en)) |-> !ctl_en); // R4

    AST_CTL_INSIDE_AD: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_en |-> ad_en); // R5

    AST_DIR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        dir_in |-> (ad_en && !rd_n)); // R6

    AST_CLK_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_clk); // R7

endmodule

bind exp_bus_gate bgc_checker #(
    .ADDR_W   (ADDR_W),
    .INT_BASE (INT_BASE),
    .INT_COUNT(INT_COUNT)
) u_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr_lo(addr_lo),
    .mreq_n (mreq_n),
    .iorq_n (iorq_n),
    .rd_n   (rd_n),
    .ad_en  (ad_en),
    .ctl_en (ctl_en),
    .dir_in (dir_in),
    .bus_clk(bus_clk)
);

// File: tb/exp_bus_gate_tb.sv
module exp_bus_gate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr_lo = 8'h00;
    logic       mreq_n = 1'b1;
    logic       iorq_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       ad_en, ctl_en, dir_in, bus_clk;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    bit  arm_m = 1'b0;

    exp_bus_gate u_dut (
        .clk(clk), .rst_n(rst_n), .addr_lo(addr_lo), .mreq_n(mreq_n),
        .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .ad_en(ad_en),
        .ctl_en(ctl_en), .dir_in(dir_in), .bus_clk(bus_clk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural expectation of the bus enable from the requirements
    function automatic bit exp_open();
        bit int_port;
        int_port = (addr_lo == 8'h01) || (addr_lo == 8'h02);
        return (mreq_n == 1'b0) || (iorq_n == 1'b0 && !int_port);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // Model of the half-period strobe delay (R4, R8)
    always @(negedge clk) begin
        if (!rst_n) arm_m = 1'b0;
        else        arm_m = exp_open();
    end

    task automatic compare_all();
        bit e;
        e = exp_open();
        chk((!iorq_n && (addr_lo == 8'h01 || addr_lo == 8'h02)) ? "R2 ad_en" :
            (!mreq_n ? "R1 ad_en" : "R3 ad_en"), ad_en, e);
        chk(!rst_n ? "R8 ctl_en" : "R4/R5 ctl_en", ctl_en, e && arm_m && rst_n);
        chk("R6 dir_in", dir_in, e && !rd_n);
        chk("R7 bus_clk", bus_clk, 1'b0);
    endtask

    // Compare just before each falling edge and just before each rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/2 - 1);
        compare_all();
        #(CLK_PERIOD/2);
        compare_all();
    end

    task automatic drive(input logic [7:0] a, input logic m, input logic io,
                         input logic r, input logic w, input int cycles);
        @(posedge clk);
        #1;
        addr_lo = a; mreq_n = m; iorq_n = io; rd_n = r; wr_n = w;
        repeat (cycles - 1) @(posedge clk);
    endtask

    task automatic idle(input int cycles);
        drive(8'h00, 1'b1, 1'b1, 1'b1, 1'b1, cycles);
    endtask

    initial begin
        // R8: reset state with a request applied
        repeat (2) @(posedge clk);
        #1 mreq_n = 1'b0; rd_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 mreq_n = 1'b1; rd_n = 1'b1;
        @(posedge clk);
        #1 rst_n = 1'b1;
        idle(2);
        // R1: memory read and write
        drive(8'h34, 1'b0, 1'b1, 1'b0, 1'b1, 3);
        idle(1);
        drive(8'h01, 1'b0, 1'b1, 1'b1, 1'b0, 3);
        idle(2);
        // R3: I/O to FFh, 00h and 03h, both directions
        drive(8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 3);
        idle(1);
        drive(8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 2);
        idle(1);
        drive(8'h03, 1'b1, 1'b0, 1'b0, 1'b1, 2);
        idle(1);
        // R2: internal window, reads and writes
        drive(8'h01, 1'b1, 1'b0, 1'b0, 1'b1, 3);
        idle(1);
        drive(8'h02, 1'b1, 1'b0, 1'b1, 1'b0, 3);
        idle(1);
        // R5: switch from external to internal port with the request held
        drive(8'hF8, 1'b1, 1'b0, 1'b0, 1'b1, 2);
        drive(8'h02, 1'b1, 1'b0, 1'b0, 1'b1, 2);
        drive(8'hF9, 1'b1, 1'b0, 1'b1, 1'b0, 2);
        idle(1);
        // R4: back-to-back single-cycle accesses with a one-cycle gap
        for (int k = 0; k < 6; k++) begin
            drive(8'(k * 37), k[0], !k[0], k[1], !k[1], 1);
            idle(1);
        end
        idle(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule